// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programming state of four DMA channels: a base address, a base count, a working address and a progress count for each one. A host reaches these registers one byte at a time through a narrow port interface. The port offset names the channel and picks between the address and the count register. One byte-pointer flip-flop, shared by every channel, decides whether an access touches the low or the high byte. The pointer flips on every access, so a 16-bit value moves as two consecutive accesses.

Writing the high byte of either register of a channel restarts that channel. The working address is loaded from the base address and the progress count is cleared. A transfer engine outside the block reports progress through an input that overwrites a channel's progress count. A read returns live values. An address read gives the working address moved forward or backward by the progress, as the channel's direction input selects. A count read gives the scaled base count minus the progress. A width parameter selects byte mode (0) or word mode (1). In word mode the decoded port offset and the returned value both move by one bit, and the base address is scaled up on reload.

Top module: `dma_chregs`

## Requirements
- R1: A synchronous active-high reset clears every base, working and progress register and the byte pointer, and sets the read data to 0. The first read after reset therefore returns 0 from the low byte.
- R2: The port offset is shifted right by WSHIFT. Bit 0 of the result selects the register (0 = address, 1 = count) and the bits above it select the channel. In word mode the lowest offset bit is ignored.
- R3: Every read or write strobe toggles the byte pointer shared by all channels. The access uses the pointer value from before the toggle (0 = low byte, 1 = high byte). Cycles without a strobe leave the pointer unchanged.
- R4: A write with the pointer at 0 replaces bits [7:0] of the selected base register. A write with the pointer at 1 replaces bits [15:8]. The other byte is kept.
- R5: A high-byte write to either register of a channel sets that channel's working address to the updated base address shifted left by WSHIFT and clears its progress count. A low-byte write reloads nothing.
- R6: A count read returns the base count shifted left by WSHIFT, minus the progress count, modulo 2^(16+WSHIFT).
- R7: An address read returns the working address plus the progress count when the channel's dir_down bit is 0, and the working address minus the progress count when it is 1. Both are taken modulo 2^(16+WSHIFT).
- R8: The returned byte is bits [WSHIFT+7:WSHIFT] of the value when the pointer was 0, and bits [WSHIFT+15:WSHIFT+8] when it was 1.
- R9: A progress strobe loads prog_cnt into the progress count of channel prog_ch. When a high-byte write restarts the same channel in the same cycle, the restart wins.
- R10: Read and write strobes are never asserted in the same cycle.
- R11: Read data is registered. It shows the result of a read strobe one clock later and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_off | input | CHW+1+WSHIFT | Port offset: channel and register select |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| dir_down | input | NCH | Per-channel address direction, 1 = decrementing |
| prog_we | input | 1 | Progress count load strobe |
| prog_ch | input | CHW | Channel for the progress load |
| prog_cnt | input | 16+WSHIFT | New progress count |

## Verification
An error in the byte pointer shows as byte-swapped data on the next read of any channel, so the bench keeps its own pointer and checks every read. A wrong base or reload value appears on the next address or count read of that channel. Those reads fall one clock after the read strobe and can come much later than the write that caused the error. The bench interleaves progress loads, direction flips and writes across all channels, so a mistake in channel decode or reload priority shows in a later read of the wrong or the same channel.

// File: rtl/dma_chregs_pkg.sv
package dma_chregs_pkg;
  // register select taken from the low bit of the shifted port offset
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  localparam int BASE_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/dma_chregs_decode.sv
module dma_chregs_decode
  import dma_chregs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0
) (
  input  logic [$clog2(NCH)+WSHIFT:0] port_off,
  output logic [$clog2(NCH)-1:0]      ch,
  output reg_sel_e                    sel
);
  localparam int CHW = $clog2(NCH);

  logic [CHW:0] idx;

  always_comb begin
    idx = port_off[CHW+WSHIFT:WSHIFT];
    ch  = idx[CHW:1];
    sel = reg_sel_e'(idx[0]);
  end
endmodule

// File: rtl/dma_chregs_chan.sv
module dma_chregs_chan
  import dma_chregs_pkg::*;
#(
  parameter int WSHIFT = 0,
  localparam int VW    = BASE_W + WSHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hi_byte,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              prog_we,
  input  logic [VW-1:0]     prog_cnt,
  output logic [BASE_W-1:0] base_cnt,
  output logic [VW-1:0]     cur_addr,
  output logic [VW-1:0]     cur_cnt,
  output logic              reload
);
  logic [BASE_W-1:0] base_addr;
  logic [BASE_W-1:0] merged;
  logic [BASE_W-1:0] addr_nx;

  always_comb begin
    merged = (sel == SEL_ADDR) ? base_addr : base_cnt;
    if (hi_byte) merged[15:8] = wr_data;
    else         merged[7:0]  = wr_data;
    reload  = wr_en && hi_byte;
    addr_nx = (wr_en && sel == SEL_ADDR) ? merged : base_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (wr_en) begin
        if (sel == SEL_ADDR) base_addr <= merged;
        else                 base_cnt  <= merged;
      end
      if (reload) begin
        cur_addr <= VW'(addr_nx) << WSHIFT;
        cur_cnt  <= '0;
      end else if (prog_we) begin
        cur_cnt <= prog_cnt;
      end
    end
  end
endmodule

// File: rtl/dma_chregs_rdval.sv
module dma_chregs_rdval
  import dma_chregs_pkg::*;
#(
  parameter int WSHIFT = 0,
  localparam int VW    = BASE_W + WSHIFT
) (
  input  logic [BASE_W-1:0] base_cnt,
  input  logic [VW-1:0]     cur_addr,
  input  logic [VW-1:0]     cur_cnt,
  input  logic              down,
  input  reg_sel_e          sel,
  input  logic              hi_byte,
  output logic [BYTE_W-1:0] byte_o
);
  logic [VW-1:0] val;
  logic [VW-1:0] shifted;

  always_comb begin
    if (sel == SEL_CNT) val = (VW'(base_cnt) << WSHIFT) - cur_cnt;
    else if (down)      val = cur_addr - cur_cnt;
    else                val = cur_addr + cur_cnt;
    shifted = hi_byte ? (val >> (WSHIFT + BYTE_W)) : (val >> WSHIFT);
    byte_o  = shifted[BYTE_W-1:0];
  end
endmodule

// File: rtl/dma_chregs.sv
module dma_chregs
  import dma_chregs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(NCH)+WSHIFT:0]   port_off,
  input  logic                          wr_stb,
  input  logic                          rd_stb,
  input  logic [7:0]                    wr_data,
  output logic [7:0]                    rd_data,
  input  logic [NCH-1:0]                dir_down,
  input  logic                          prog_we,
  input  logic [$clog2(NCH)-1:0]        prog_ch,
  input  logic [BASE_W+WSHIFT-1:0]      prog_cnt
);
  localparam int CHW = $clog2(NCH);
  localparam int VW  = BASE_W + WSHIFT;

  logic [CHW-1:0]    dec_ch;
  reg_sel_e          dec_sel;
  logic              ptr_hi;
  logic [BASE_W-1:0] base_cnt_a [NCH];
  logic [VW-1:0]     cur_addr_a [NCH];
  logic [VW-1:0]     cur_cnt_a  [NCH];
  logic [NCH-1:0]    reload_vec;
  logic [7:0]        rd_byte;

  dma_chregs_decode #(.NCH(NCH), .WSHIFT(WSHIFT)) u_dec (
    .port_off (port_off),
    .ch       (dec_ch),
    .sel      (dec_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chregs_chan #(.WSHIFT(WSHIFT)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_stb && (dec_ch == CHW'(i))),
      .hi_byte  (ptr_hi),
      .sel      (dec_sel),
      .wr_data  (wr_data),
      .prog_we  (prog_we && (prog_ch == CHW'(i))),
      .prog_cnt (prog_cnt),
      .base_cnt (base_cnt_a[i]),
      .cur_addr (cur_addr_a[i]),
      .cur_cnt  (cur_cnt_a[i]),
      .reload   (reload_vec[i])
    );
  end

  dma_chregs_rdval #(.WSHIFT(WSHIFT)) u_rd (
    .base_cnt (base_cnt_a[dec_ch]),
    .cur_addr (cur_addr_a[dec_ch]),
    .cur_cnt  (cur_cnt_a[dec_ch]),
    .down     (dir_down[dec_ch]),
    .sel      (dec_sel),
    .hi_byte  (ptr_hi),
    .byte_o   (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_stb || wr_stb) ptr_hi  <= ~ptr_hi;
      if (rd_stb)           rd_data <= rd_byte;
    end
  end
endmodule

// File: rtl/dma_chregs_chk.sv
module dma_chregs_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_stb,
  input logic           wr_stb,
  input logic [7:0]     rd_data,
  input logic           ptr_hi,
  input logic [NCH-1:0] reload_vec
);
  // R10
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |=> (ptr_hi != $past(ptr_hi)));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb || wr_stb) |=> $stable(ptr_hi));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ptr_hi && rd_data == 8'h00));

  // R5
  reload_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_vec != '0) |-> (wr_stb && ptr_hi && $onehot0(reload_vec)));
endmodule

bind dma_chregs dma_chregs_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .rd_data    (rd_data),
  .ptr_hi     (ptr_hi),
  .reload_vec (reload_vec)
);

// File: tb/dma_chregs_bench.sv
module dma_chregs_bench;
  localparam int NCH = 4;
  localparam int WS  = 1;
  localparam int CHW = 2;
  localparam int OW  = CHW + 1 + WS;
  localparam int VW  = 16 + WS;

  logic          clk = 1'b0;
  logic          rst;
  logic [OW-1:0] port_off;
  logic          wr_stb, rd_stb;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic [NCH-1:0] dir_down;
  logic          prog_we;
  logic [CHW-1:0] prog_ch;
  logic [VW-1:0] prog_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0]   m_base [NCH][2];
  logic [VW-1:0] m_addr [NCH];
  logic [VW-1:0] m_cnt  [NCH];
  logic          m_ptr;

  always #10 clk = ~clk;

  dma_chregs #(.NCH(NCH), .WSHIFT(WS)) u_dma_chregs (
    .clk(clk), .rst(rst), .port_off(port_off), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .rd_data(rd_data), .dir_down(dir_down), .prog_we(prog_we),
    .prog_ch(prog_ch), .prog_cnt(prog_cnt)
  );

  function automatic logic [7:0] exp_byte(input int ch, input bit sel, input bit hi);
    logic [VW-1:0] v;
    if (sel)              v = ({1'b0, m_base[ch][1]} << WS) - m_cnt[ch];
    else if (dir_down[ch]) v = m_addr[ch] - m_cnt[ch];
    else                  v = m_addr[ch] + m_cnt[ch];
    v = v >> (WS + (hi ? 8 : 0));
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_stb = 0; rd_stb = 0; prog_we = 0;
    @(negedge clk);
  endtask

  // write one byte; optional progress load in the same cycle
  task automatic wr(input logic [OW-1:0] off, input logic [7:0] d,
                    input bit pw, input int pc, input logic [VW-1:0] pv);
    int ch; bit sel; bit rl;
    ch  = int'(off >> (WS + 1));
    sel = off[WS];
    port_off = off; wr_data = d; wr_stb = 1; rd_stb = 0;
    prog_we = pw; prog_ch = CHW'(pc); prog_cnt = pv;
    @(negedge clk);
    wr_stb = 0; prog_we = 0;
    if (m_ptr) m_base[ch][sel][15:8] = d;
    else       m_base[ch][sel][7:0]  = d;
    rl = m_ptr;
    if (rl) begin
      m_addr[ch] = {1'b0, m_base[ch][0]} << WS;
      m_cnt[ch]  = '0;
    end
    if (pw && !(rl && pc == ch)) m_cnt[pc] = pv;
    m_ptr = ~m_ptr;
  endtask

  task automatic rd(input logic [OW-1:0] off, input string req);
    int ch; bit sel; logic [7:0] e;
    ch  = int'(off >> (WS + 1));
    sel = off[WS];
    e   = exp_byte(ch, sel, m_ptr);
    port_off = off; rd_stb = 1; wr_stb = 0; prog_we = 0;
    @(negedge clk);
    rd_stb = 0;
    m_ptr = ~m_ptr;
    check(req, rd_data, e);
  endtask

  task automatic prog(input int pc, input logic [VW-1:0] pv);
    prog_we = 1; prog_ch = CHW'(pc); prog_cnt = pv; wr_stb = 0; rd_stb = 0;
    @(negedge clk);
    prog_we = 0;
    m_cnt[pc] = pv;
  endtask

  function automatic logic [OW-1:0] mk_off(input int ch, input bit sel, input bit junk);
    return OW'({ch[CHW-1:0], sel, junk});
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; wr_stb = 0; rd_stb = 0; prog_we = 0; port_off = '0;
    wr_data = '0; dir_down = '0; prog_ch = '0; prog_cnt = '0;
    for (int c = 0; c < NCH; c++) begin
      m_base[c][0] = '0; m_base[c][1] = '0; m_addr[c] = '0; m_cnt[c] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd(mk_off(0, 0, 0), "R1 low byte after reset");
    rd(mk_off(3, 1, 0), "R1 high byte after reset");

    // R4 R5 R7 R8: program ch2 address, then a progress value
    wr(mk_off(2, 0, 0), 8'h34, 0, 0, '0);
    wr(mk_off(2, 0, 0), 8'h92, 0, 0, '0);
    prog(2, 17'd5);
    rd(mk_off(2, 0, 0), "R7 up addr lo");
    rd(mk_off(2, 0, 0), "R8 up addr hi");
    dir_down[2] = 1;
    rd(mk_off(2, 0, 1), "R7 down addr lo, R2 offset lsb ignored");
    rd(mk_off(2, 0, 0), "R7 down addr hi");
    // R6: count with progress exceeding the base wraps
    wr(mk_off(2, 1, 0), 8'h02, 0, 0, '0);
    wr(mk_off(2, 1, 0), 8'h00, 0, 0, '0);
    prog(2, 17'd9);
    rd(mk_off(2, 1, 0), "R6 count wrap lo");
    rd(mk_off(2, 1, 0), "R6 count wrap hi");
    // R5: low-byte write reloads nothing, progress stays
    wr(mk_off(2, 0, 0), 8'hff, 0, 0, '0);
    rd(mk_off(2, 0, 0), "R5 no reload on low byte (hi ptr read)");
    // R3: pointer shared between channels: lo on ch1, hi lands on ch3
    wr(mk_off(1, 0, 0), 8'hab, 0, 0, '0);
    wr(mk_off(3, 0, 0), 8'hcd, 0, 0, '0);
    rd(mk_off(3, 0, 0), "R3 shared pointer lo");
    rd(mk_off(1, 0, 0), "R3 shared pointer hi");
    // R9: restart wins over a same-cycle progress load on the same channel
    prog(0, 17'h0100);
    wr(mk_off(0, 1, 0), 8'h10, 0, 0, '0);
    wr(mk_off(0, 1, 0), 8'h00, 1, 0, 17'h0077);
    rd(mk_off(0, 1, 0), "R9 restart priority lo");
    rd(mk_off(0, 1, 0), "R9 restart priority hi");
    // R9: progress to another channel in the same cycle still lands
    wr(mk_off(1, 0, 0), 8'h00, 0, 0, '0);
    wr(mk_off(1, 0, 0), 8'h40, 1, 3, 17'h0033);
    rd(mk_off(3, 1, 0), "R9 other channel progress lo");
    rd(mk_off(3, 1, 0), "R9 other channel progress hi");
    // R11: read data held while idle
    idle(); idle();
    check("R11 hold", rd_data, exp_byte(3, 1, 1));

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op; int ch; bit sel;
      op = $urandom_range(0, 9);
      ch = $urandom_range(0, NCH - 1);
      sel = $urandom_range(0, 1);
      if (op < 4) begin
        if ($urandom_range(0, 3) == 0)
          wr(mk_off(ch, sel, $urandom_range(0, 1)), 8'($urandom), 1,
             $urandom_range(0, NCH - 1), VW'($urandom));
        else
          wr(mk_off(ch, sel, $urandom_range(0, 1)), 8'($urandom), 0, 0, '0);
      end else if (op < 8) begin
        rd(mk_off(ch, sel, $urandom_range(0, 1)), "R2 R6 R7 R8 random read");
      end else if (op == 8) begin
        prog(ch, VW'($urandom));
      end else begin
        dir_down = NCH'($urandom);
        idle();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule